// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel display panel. It takes a mode description as inputs: active width and height, the front porch, sync length and back porch in each direction, per-sync active-low flags, an option that forces both syncs active-high, an interlace flag and a flag for the secondary output channel. From these it derives the line length, the frame length and the offsets of active video. It then runs a pixel counter and a line counter, advancing once per pixel-clock enable, and drives HSYNC, VSYNC, data-enable, the pixel position, a field flag and a start-delay value for downstream pipelines.

Each line starts with horizontal sync. Active video begins a fixed offset after that start, equal to sync length plus back porch, and the front porch closes the line. Vertical timing uses the same scheme in lines. The vertical sync window is compared in half-line steps, so the odd field of an interlaced mode can place its sync half a line later. Mode inputs are captured while the block is disabled and again at every frame end. Software can therefore change them at any time without tearing the current frame. The pad drivers stay off after reset until the mode has been reported as programmed.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line lasts h_act + h_fp + h_sync + h_bp pixel enables. HSYNC is asserted for the first h_sync pixels of each line, counting from pixel 0.
- R2: DE is high for the line pixels from h_sync + h_bp up to h_sync + h_bp + h_act - 1 that fall inside active lines. In that window x_pos equals the pixel index minus (h_sync + h_bp). Outside it x_pos is 0.
- R3: A frame lasts (active lines) + v_fp + v_sync + v_bp lines. VSYNC covers the first v_sync lines. Active lines begin at line v_sync + v_bp, where y_pos is 0, and y_pos increments by one per active line.
- R4: hs_low = 1 inverts the HSYNC output level and vs_low = 1 inverts the VSYNC output level. With a flag at 0, its sync is high while asserted.
- R5: force_hi = 1 removes both inversions, whatever hs_low and vs_low hold.
- R6: start_dly = min(30, B'), where B = v_fp + v_sync + v_bp. B is halved, rounding down, when ilace = 1, and reduced by 2 when sec_chan = 1. A result below 0 gives 0.
- R7: With ilace = 1, each field has v_act/2 active lines, rounded down, and field toggles at every field end. In field 1, VSYNC starts and ends floor(line length / 2) pixels later than in field 0. With ilace = 0, field stays 0.
- R8: drive_en is 0 from reset until the first cycle after mode_done is seen high. It then stays 1 until the next reset.
- R9: While en is 0 the position returns to pixel 0 of line 0. DE, x_pos, y_pos and field are 0, and both syncs sit at their inactive level. Timing restarts from the start of a line when en returns.
- R10: In a cycle with pix_ce = 0 the position does not advance, and the next outputs repeat the current ones.
- R11: Mode inputs are captured while en is 0 and at the end of each frame (or field). A change made mid-frame takes effect from the next frame.
- R12: All timing outputs are registered. Each one reflects the position the counters held one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | Pixel-clock enable; position advances when high |
| en | input | 1 | Run enable; low holds the position at the origin |
| mode_done | input | 1 | Pulse reporting that the mode inputs have been programmed |
| h_act | input | HW | Active pixels per line |
| h_fp | input | HW | Horizontal front porch |
| h_sync | input | HW | Horizontal sync length |
| h_bp | input | HW | Horizontal back porch |
| v_act | input | VW | Active lines per frame |
| v_fp | input | VW | Vertical front porch |
| v_sync | input | VW | Vertical sync length |
| v_bp | input | VW | Vertical back porch |
| hs_low | input | 1 | HSYNC is active-low |
| vs_low | input | 1 | VSYNC is active-low |
| force_hi | input | 1 | Override: both syncs active-high |
| ilace | input | 1 | Interlaced mode |
| sec_chan | input | 1 | Secondary output channel (start-delay correction) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| x_pos | output | HW | Active pixel column |
| y_pos | output | VW | Active line row |
| field | output | 1 | Current field of an interlaced mode |
| start_dly | output | 5 | Saturated start delay derived from vertical blanking |
| drive_en | output | 1 | Pad output enable; 0 keeps the display lines tristated |

## Verification
A pixel counter off by one shows up within a single line: DE, x_pos and HSYNC move together by one pixel. A wrong line count or wrong latched mode is exposed at the next frame boundary by VSYNC, y_pos or field. The bench therefore compares every output on every clock against an arithmetic model of position and mode, across progressive and interlaced modes, irregular pixel enables, disable periods and mid-frame mode changes. An error in field or half-line handling appears at the first odd field, within one field time.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int DLY_W   = 5;
  localparam int DLY_MAX = 30;

  // Start delay from the vertical blanking total, with interlace halving,
  // secondary-channel correction and saturation on both sides.
  function automatic logic [DLY_W-1:0] calc_start_dly(input int blank, input logic ilace,
                                                      input logic sec);
    int d;
    d = blank;
    if (ilace) d = d / 2;
    if (sec) d = d - 2;
    if (d < 0) d = 0;
    if (d > DLY_MAX) d = DLY_MAX;
    return DLY_W'(d);
  endfunction
endpackage

// File: rtl/lcdt_mode_latch.sv
module lcdt_mode_latch #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic                      clk,
  input  logic                      load,
  input  logic [HW-1:0]             h_act_i,
  input  logic [HW-1:0]             h_fp_i,
  input  logic [HW-1:0]             h_sync_i,
  input  logic [HW-1:0]             h_bp_i,
  input  logic [VW-1:0]             v_act_i,
  input  logic [VW-1:0]             v_fp_i,
  input  logic [VW-1:0]             v_sync_i,
  input  logic [VW-1:0]             v_bp_i,
  input  logic                      hs_low_i,
  input  logic                      vs_low_i,
  input  logic                      force_hi_i,
  input  logic                      ilace_i,
  input  logic                      sec_i,
  output logic [HW-1:0]             h_total,
  output logic [HW-1:0]             h_start,
  output logic [HW-1:0]             h_act,
  output logic [HW-1:0]             h_sync,
  output logic [HW-1:0]             h_half,
  output logic [VW-1:0]             v_total,
  output logic [VW-1:0]             v_start,
  output logic [VW-1:0]             v_act,
  output logic [VW-1:0]             v_sync,
  output logic                      ilace,
  output logic                      hs_inv,
  output logic                      vs_inv,
  output logic [lcdt_pkg::DLY_W-1:0] start_dly
);
  logic [HW-1:0] h_start_n, h_total_n;
  logic [VW-1:0] v_act_n, v_start_n, v_total_n;
  int            blank_n;

  always_comb begin
    h_start_n = h_sync_i + h_bp_i;
    h_total_n = h_act_i + h_fp_i + h_start_n;
    v_act_n   = ilace_i ? (v_act_i >> 1) : v_act_i;
    v_start_n = v_sync_i + v_bp_i;
    v_total_n = v_act_n + v_fp_i + v_start_n;
    blank_n   = int'(v_fp_i) + int'(v_sync_i) + int'(v_bp_i);
  end

  // Shadow copy of the mode, refreshed only when the caller allows it.
  always_ff @(posedge clk) begin
    if (load) begin
      h_total   <= h_total_n;
      h_start   <= h_start_n;
      h_act     <= h_act_i;
      h_sync    <= h_sync_i;
      h_half    <= h_total_n >> 1;
      v_total   <= v_total_n;
      v_start   <= v_start_n;
      v_act     <= v_act_n;
      v_sync    <= v_sync_i;
      ilace     <= ilace_i;
      hs_inv    <= hs_low_i & ~force_hi_i;
      vs_inv    <= vs_low_i & ~force_hi_i;
      start_dly <= lcdt_pkg::calc_start_dly(blank_n, ilace_i, sec_i);
    end
  end
endmodule

// File: rtl/lcdt_wrap_cnt.sv
module lcdt_wrap_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  assign wrap = step && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (step)   cnt <= cnt + ONE;
  end
endmodule

// File: rtl/lcdt_out_stage.sv
module lcdt_out_stage #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          field_st,
  input  logic [HW-1:0] h_start,
  input  logic [HW-1:0] h_act,
  input  logic [HW-1:0] h_sync,
  input  logic [HW-1:0] h_half,
  input  logic [VW-1:0] v_start,
  input  logic [VW-1:0] v_act,
  input  logic [VW-1:0] v_sync,
  input  logic          hs_inv,
  input  logic          vs_inv,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] x_pos,
  output logic [VW-1:0] y_pos,
  output logic          field
);
  logic [HW:0]   h_end;
  logic [VW:0]   v_end;
  logic [VW:0]   half_idx;
  logic [VW+1:0] vs_beg, vs_end;
  logic          h_vis, v_vis, hs_on, vs_on, vis;

  always_comb begin
    h_end    = {1'b0, h_start} + {1'b0, h_act};
    v_end    = {1'b0, v_start} + {1'b0, v_act};
    h_vis    = (hcnt >= h_start) && ({1'b0, hcnt} < h_end);
    v_vis    = (vcnt >= v_start) && ({1'b0, vcnt} < v_end);
    hs_on    = hcnt < h_sync;
    // Vertical sync window compared in half lines; odd field shifts by one.
    half_idx = {vcnt, (hcnt >= h_half)};
    vs_beg   = {{(VW+1){1'b0}}, field_st};
    vs_end   = {1'b0, v_sync, 1'b0} + vs_beg;
    vs_on    = ({1'b0, half_idx} >= vs_beg) && ({1'b0, half_idx} < vs_end);
    vis      = en && h_vis && v_vis;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
      de    <= 1'b0;
      x_pos <= '0;
      y_pos <= '0;
      field <= 1'b0;
    end else begin
      hsync <= (en && hs_on) ^ hs_inv;
      vsync <= (en && vs_on) ^ vs_inv;
      de    <= vis;
      x_pos <= vis ? (hcnt - h_start) : '0;
      y_pos <= vis ? (vcnt - v_start) : '0;
      field <= en && field_st;
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pix_ce,
  input  logic                       en,
  input  logic                       mode_done,
  input  logic [HW-1:0]              h_act,
  input  logic [HW-1:0]              h_fp,
  input  logic [HW-1:0]              h_sync,
  input  logic [HW-1:0]              h_bp,
  input  logic [VW-1:0]              v_act,
  input  logic [VW-1:0]              v_fp,
  input  logic [VW-1:0]              v_sync,
  input  logic [VW-1:0]              v_bp,
  input  logic                       hs_low,
  input  logic                       vs_low,
  input  logic                       force_hi,
  input  logic                       ilace,
  input  logic                       sec_chan,
  output logic                       hsync,
  output logic                       vsync,
  output logic                       de,
  output logic [HW-1:0]              x_pos,
  output logic [VW-1:0]              y_pos,
  output logic                       field,
  output logic [lcdt_pkg::DLY_W-1:0] start_dly,
  output logic                       drive_en
);
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [VW-1:0] V_ONE = VW'(1);

  logic [HW-1:0] lat_h_total, lat_h_start, lat_h_act, lat_h_sync, lat_h_half;
  logic [VW-1:0] lat_v_total, lat_v_start, lat_v_act, lat_v_sync;
  logic          lat_ilace, lat_hs_inv, lat_vs_inv;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          h_wrap, v_wrap, field_q, latch_load;

  assign latch_load = rst || !en || v_wrap;

  lcdt_mode_latch #(.HW(HW), .VW(VW)) u_latch (
    .clk(clk), .load(latch_load),
    .h_act_i(h_act), .h_fp_i(h_fp), .h_sync_i(h_sync), .h_bp_i(h_bp),
    .v_act_i(v_act), .v_fp_i(v_fp), .v_sync_i(v_sync), .v_bp_i(v_bp),
    .hs_low_i(hs_low), .vs_low_i(vs_low), .force_hi_i(force_hi),
    .ilace_i(ilace), .sec_i(sec_chan),
    .h_total(lat_h_total), .h_start(lat_h_start), .h_act(lat_h_act),
    .h_sync(lat_h_sync), .h_half(lat_h_half),
    .v_total(lat_v_total), .v_start(lat_v_start), .v_act(lat_v_act),
    .v_sync(lat_v_sync), .ilace(lat_ilace), .hs_inv(lat_hs_inv),
    .vs_inv(lat_vs_inv), .start_dly(start_dly)
  );

  lcdt_wrap_cnt #(.W(HW)) u_hcnt (
    .clk(clk), .rst(rst), .clr(!en), .step(en && pix_ce),
    .last(lat_h_total - H_ONE), .cnt(hcnt), .wrap(h_wrap)
  );

  lcdt_wrap_cnt #(.W(VW)) u_vcnt (
    .clk(clk), .rst(rst), .clr(!en), .step(h_wrap),
    .last(lat_v_total - V_ONE), .cnt(vcnt), .wrap(v_wrap)
  );

  // Field state follows the mode being latched at the same edge.
  always_ff @(posedge clk) begin
    if (rst || !en)  field_q <= 1'b0;
    else if (v_wrap) field_q <= ilace ? ~field_q : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            drive_en <= 1'b0;
    else if (mode_done) drive_en <= 1'b1;
  end

  lcdt_out_stage #(.HW(HW), .VW(VW)) u_out (
    .clk(clk), .rst(rst), .en(en), .hcnt(hcnt), .vcnt(vcnt), .field_st(field_q),
    .h_start(lat_h_start), .h_act(lat_h_act), .h_sync(lat_h_sync), .h_half(lat_h_half),
    .v_start(lat_v_start), .v_act(lat_v_act), .v_sync(lat_v_sync),
    .hs_inv(lat_hs_inv), .vs_inv(lat_vs_inv),
    .hsync(hsync), .vsync(vsync), .de(de), .x_pos(x_pos), .y_pos(y_pos), .field(field)
  );
endmodule

module lcd_timing_gen_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       en,
  input logic                       pix_ce,
  input logic                       mode_done,
  input logic                       de,
  input logic [HW-1:0]              x_pos,
  input logic [VW-1:0]              y_pos,
  input logic                       drive_en,
  input logic [lcdt_pkg::DLY_W-1:0] start_dly,
  input logic [HW-1:0]              hcnt,
  input logic [HW-1:0]              act_w,
  input logic                       field_st,
  input logic                       ilace_st
);
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!de && x_pos == '0 && y_pos == '0));

  assert_ce_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (en && !pix_ce) |=> $stable(hcnt));

  assert_oe_after_load_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_en) |-> $past(mode_done));

  assert_x_bound_R2: assert property (@(posedge clk) disable iff (rst)
    de |-> (x_pos < act_w));

  assert_field_prog_R7: assert property (@(posedge clk) disable iff (rst)
    !ilace_st |-> !field_st);

  assert_dly_sat_R6: assert property (@(posedge clk) disable iff (rst)
    start_dly <= 5'd30);
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .pix_ce(pix_ce), .mode_done(mode_done),
  .de(de), .x_pos(x_pos), .y_pos(y_pos), .drive_en(drive_en), .start_dly(start_dly),
  .hcnt(hcnt), .act_w(lat_h_act), .field_st(field_q), .ilace_st(lat_ilace)
);

// File: tb/lcd_timing_gen_bench.sv
`timescale 1ns/1ps
module lcd_timing_gen_bench;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_ce = 1'b1, en = 1'b0, mode_done = 1'b0;
  logic [HW-1:0] m_hact, m_hfp, m_hs, m_hbp;
  logic [VW-1:0] m_vact, m_vfp, m_vs, m_vbp;
  logic m_hl = 1'b0, m_vl = 1'b0, m_fh = 1'b0, m_il = 1'b0, m_sec = 1'b0;
  logic hsync, vsync, de, field, drive_en;
  logic [HW-1:0] x_pos;
  logic [VW-1:0] y_pos;
  logic [4:0] start_dly;

  int checks = 0, fails = 0;
  bit chk_on = 1'b0, done = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  lcd_timing_gen #(.HW(HW), .VW(VW)) u_lcd_timing_gen (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .en(en), .mode_done(mode_done),
    .h_act(m_hact), .h_fp(m_hfp), .h_sync(m_hs), .h_bp(m_hbp),
    .v_act(m_vact), .v_fp(m_vfp), .v_sync(m_vs), .v_bp(m_vbp),
    .hs_low(m_hl), .vs_low(m_vl), .force_hi(m_fh), .ilace(m_il), .sec_chan(m_sec),
    .hsync(hsync), .vsync(vsync), .de(de), .x_pos(x_pos), .y_pos(y_pos),
    .field(field), .start_dly(start_dly), .drive_en(drive_en)
  );

  // Reference model: mode copy captured when disabled or at frame end.
  int Lha, Lhf, Lhs, Lhb, Lva, Lvf, Lvs, Lvb;
  bit Lhl, Lvl, Lfh, Lil, Lsec;
  int bh, bl, bf;
  int htot, hst, va, lines, vst, hl;
  bit hinv, vinv, vis;
  bit e_hs, e_vs, e_de, e_fld, e_oe;
  int e_x, e_y;

  always_comb begin
    htot  = Lha + Lhf + Lhs + Lhb;
    hst   = Lhs + Lhb;
    va    = Lil ? Lva / 2 : Lva;
    lines = va + Lvf + Lvs + Lvb;
    vst   = Lvs + Lvb;
    hinv  = Lhl && !Lfh;
    vinv  = Lvl && !Lfh;
  end

  function automatic int dly_exp();
    int d;
    d = Lvf + Lvs + Lvb;
    if (Lil) d = d / 2;
    if (Lsec) d = d - 2;
    if (d < 0) d = 0;
    if (d > 30) d = 30;
    return d;
  endfunction

  always @(posedge clk) begin
    if (rst || !en) begin
      Lha <= int'(m_hact); Lhf <= int'(m_hfp); Lhs <= int'(m_hs); Lhb <= int'(m_hbp);
      Lva <= int'(m_vact); Lvf <= int'(m_vfp); Lvs <= int'(m_vs); Lvb <= int'(m_vbp);
      Lhl <= m_hl; Lvl <= m_vl; Lfh <= m_fh; Lil <= m_il; Lsec <= m_sec;
    end
    if (rst) begin
      e_hs <= 0; e_vs <= 0; e_de <= 0; e_x <= 0; e_y <= 0; e_fld <= 0; e_oe <= 0;
      bh <= 0; bl <= 0; bf <= 0;
    end else begin
      if (mode_done) e_oe <= 1'b1;
      vis   = en && bh >= hst && bh < hst + Lha && bl >= vst && bl < vst + va;
      e_de  <= vis;
      e_x   <= vis ? bh - hst : 0;
      e_y   <= vis ? bl - vst : 0;
      e_hs  <= (en && bh < Lhs) ^ hinv;
      hl    = 2 * bl + ((bh >= htot / 2) ? 1 : 0);
      e_vs  <= (en && hl >= bf && hl < 2 * Lvs + bf) ^ vinv;
      e_fld <= en && (bf != 0);
      if (!en) begin
        bh <= 0; bl <= 0; bf <= 0;
      end else if (pix_ce) begin
        if (bh == htot - 1) begin
          bh <= 0;
          if (bl == lines - 1) begin
            bl <= 0;
            bf <= m_il ? 1 - bf : 0;
            Lha <= int'(m_hact); Lhf <= int'(m_hfp); Lhs <= int'(m_hs); Lhb <= int'(m_hbp);
            Lva <= int'(m_vact); Lvf <= int'(m_vfp); Lvs <= int'(m_vs); Lvb <= int'(m_vbp);
            Lhl <= m_hl; Lvl <= m_vl; Lfh <= m_fh; Lil <= m_il; Lsec <= m_sec;
          end else bl <= bl + 1;
        end else bh <= bh + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s (phase %s) act=%0d exp=%0d at %0t", req, what, tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !rst) begin
      chk("R1 R4", "hsync", int'(hsync), int'(e_hs));
      chk("R3 R7", "vsync", int'(vsync), int'(e_vs));
      chk("R2 R12", "de", int'(de), int'(e_de));
      chk("R2", "x_pos", int'(x_pos), e_x);
      chk("R3", "y_pos", int'(y_pos), e_y);
      chk("R7", "field", int'(field), int'(e_fld));
      chk("R6 R11", "start_dly", int'(start_dly), dly_exp());
      chk("R8", "drive_en", int'(drive_en), int'(e_oe));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int ha, hf, hs, hb, vaa, vf, vs, vb);
    m_hact = HW'(ha); m_hfp = HW'(hf); m_hs = HW'(hs); m_hbp = HW'(hb);
    m_vact = VW'(vaa); m_vfp = VW'(vf); m_vs = VW'(vs); m_vbp = VW'(vb);
  endtask

  initial begin
    set_mode(8, 2, 3, 2, 4, 1, 2, 1);
    cyc(4);
    // Reset state (R8, R9)
    chk("R8", "drive_en in reset", int'(drive_en), 0);
    chk("R9", "de in reset", int'(de), 0);
    chk("R9", "x_pos in reset", int'(x_pos), 0);
    chk("R6", "start_dly in reset", int'(start_dly), 4);
    rst = 1'b0;
    chk_on = 1'b1;
    tag = "R9"; cyc(5);
    chk("R8", "drive_en before load", int'(drive_en), 0);
    mode_done = 1'b1; cyc(1); mode_done = 1'b0; cyc(1);
    chk("R8", "drive_en after load", int'(drive_en), 1);
    // Progressive sweep, two frames and more
    tag = "R1"; en = 1'b1; cyc(260);
    // Irregular pixel enables
    tag = "R10";
    for (int i = 0; i < 300; i++) begin pix_ce = 1'($urandom % 2); cyc(1); end
    pix_ce = 1'b1;
    // Polarity flags, applied mid-frame and taking effect at frame end
    tag = "R4"; m_hl = 1'b1; m_vl = 1'b1; cyc(260);
    tag = "R5"; m_fh = 1'b1; cyc(260);
    m_fh = 1'b0; m_vl = 1'b0;
    // Mid-frame geometry change
    tag = "R11"; cyc(37); set_mode(6, 3, 2, 4, 3, 2, 1, 2); cyc(300);
    // Disable window
    tag = "R9"; en = 1'b0; cyc(20);
    chk("R9", "de while disabled", int'(de), 0);
    chk("R9", "hsync idle level", int'(hsync), 1);
    en = 1'b1;
    // Interlaced, three fields and more
    tag = "R7"; m_hl = 1'b0; en = 1'b0; m_il = 1'b1;
    set_mode(8, 2, 3, 2, 6, 1, 2, 1); cyc(1); en = 1'b1; cyc(360);
    // Start delay: saturation, halving and secondary correction
    tag = "R6"; en = 1'b0; m_il = 1'b0; set_mode(5, 1, 2, 1, 2, 20, 10, 5); cyc(2);
    chk("R6", "start_dly saturated", int'(start_dly), 30);
    en = 1'b1; cyc(400);
    en = 1'b0; m_il = 1'b1; m_sec = 1'b1; cyc(2);
    chk("R6", "start_dly interlace secondary", int'(start_dly), 15);
    en = 1'b1; cyc(420);
    en = 1'b0; m_il = 1'b0; set_mode(5, 1, 2, 1, 3, 0, 1, 0); cyc(2);
    chk("R6", "start_dly floor", int'(start_dly), 0);
    en = 1'b1; cyc(120);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule